// File: doc/BRIEF.md
# Multichannel Binary-Code Sliding Correlator

This block correlates a stream of samples against stored one-bit code sequences. Samples arrive one at a time, each tagged with a channel number and with the index of the code sequence to use. Every accepted sample goes into its channel's circular tap buffer. The sample then starts exactly one correlation over that channel's newest window of `NUM_TAP` samples. Each correlation produces exactly one result, which carries the channel tag and an optional frame marker.

The code store is loaded row by row, with `MWIDTH` coefficient bits per row. The datapath evaluates `MWIDTH` taps per clock, so one correlation takes `NUM_TAP/MWIDTH` accumulate cycles. The interpretation of the coefficients and of the data is fixed by a parameter:
- **Unsigned:** a coefficient of 1 passes the tap and 0 contributes nothing.
- **Signed:** 1 means +1 and 0 means -1.

With an oversampling factor `OS`, each channel keeps `OS*NUM_TAP` samples. Only every `OS`-th sample, counted back from the newest, takes part in the correlation.

The input side holds a single job. The ready output stays low while a correlation is in flight, so taps that are being read can never be overwritten.

Top module: `code_correlator`

## Requirements
- R1: During and after reset, `crdy` is 1 and `ordy` is 0. Reset clears every tap buffer and channel pointer to zero, so missing history contributes zero to the first results.
- R2: A sample is accepted on a clock edge where `irdy` and `crdy` are both 1. `crdy` is 0 from the next cycle onward. Exactly one result follows: `ordy` is high for one cycle, `NUM_TAP/MWIDTH` edges after the accepting edge, and `crdy` is 1 again in that same cycle.
- R3: In unsigned mode (`IS_SIGNED=0`), `dout` is the unsigned sum of the taps whose coefficient bit is 1.
- R4: In signed mode (`IS_SIGNED=1`), samples are two's complement. `dout` is a two's complement value equal to the sum of +tap for coefficient 1 and -tap for coefficient 0.
- R5: Coefficient bit j (j = 0 … NUM_TAP-1) of a sequence multiplies the sample of age j*OS, where age 0 is the newest sample. So bit 0 meets the newest sample and bit NUM_TAP-1 meets the oldest one used.
- R6: The code store has `NUM_SEQ*NUM_TAP/MWIDTH` rows of `MWIDTH` bits, written by `coeffWr` at `coeffAddr`. Sequence s occupies rows s*NUM_TAP/MWIDTH onward. Bit m of the k-th row of a sequence is coefficient k*MWIDTH+m.
- R7: Each channel has its own tap buffer and write pointer. The code sequence is chosen per sample by `codeSelIn`. `chanOut` on a result equals the `chanIn` of its sample.
- R8: `blockStartOut` is 1 only together with `ordy`, and only on the result of a sample that was accepted with `blockStartIn` = 1.
- R9: Each channel stores `OS*NUM_TAP` samples in a circular buffer, so windows that span a pointer wrap use the correct older samples.
- R10: An `irdy` pulse while `crdy` is 0 is ignored. It writes no tap, moves no pointer and produces no result.
- R11: The result width is DWIDTH + clog2(NUM_TAP) + 1 bits.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| crdy | output | 1 | Block can accept a sample |
| irdy | input | 1 | One-cycle transfer strobe for a sample |
| din | input | DWIDTH | Sample value |
| chanIn | input | clog2(NUM_CHAN) | Channel of the sample |
| codeSelIn | input | clog2(NUM_SEQ) | Code sequence used for this sample |
| blockStartIn | input | 1 | Frame marker of the sample |
| ordy | output | 1 | Result valid (one-cycle pulse) |
| dout | output | DWIDTH+clog2(NUM_TAP)+1 | Correlation result |
| chanOut | output | clog2(NUM_CHAN) | Channel of the result |
| blockStartOut | output | 1 | Frame marker of the result |
| coeffAddr | input | clog2(NUM_SEQ*NUM_TAP/MWIDTH) | Code store row |
| coeffWdat | input | MWIDTH | Code store row data |
| coeffWr | input | 1 | Code store write enable |

## Verification
The bound checker watches the handshake on every cycle:
- `crdy` drops right after an acceptance.
- `ordy` is a one-cycle pulse that arrives exactly `NUM_TAP/MWIDTH` edges after its acceptance, with `crdy` back high.
- The frame marker appears only with a result.
- The channel tag stays in range.

The arithmetic can only be shown by the bench scenarios, which compare every result against a software model of both an unsigned, non-oversampled instance and a signed instance with `OS=2`. These scenarios cover:
- bit ordering, probed with single-bit codes;
- the row layout of the example code sequences;
- zero history after reset;
- circular-buffer wrap;
- `irdy` pulses ignored while busy.

// File: rtl/corr_pkg.sv
package corr_pkg;
  typedef struct packed {
    logic load;    // sample accepted this cycle
    logic step;    // accumulate one row of taps
    logic finish;  // last row: publish the result
  } corrStrobes_t;

  function automatic int safeClog2(input int n);
    return (n > 1) ? $clog2(n) : 1;
  endfunction
endpackage

// File: rtl/corr_ctrl.sv
module corr_ctrl
  import corr_pkg::*;
#(
  parameter int STEPS = 4,
  parameter int SW    = 2
) (
  input  logic         clk,
  input  logic         rst,
  input  logic         irdy,
  output logic         crdy,
  output corrStrobes_t strobes,
  output logic [SW-1:0] stepCnt
);
  typedef enum logic {ST_IDLE, ST_RUN} ctrlState_t;
  ctrlState_t state;

  always_comb begin
    crdy           = (state == ST_IDLE);
    strobes.load   = irdy && crdy;
    strobes.step   = (state == ST_RUN);
    strobes.finish = (state == ST_RUN) && (stepCnt == SW'(STEPS - 1));
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      state   <= ST_IDLE;
      stepCnt <= '0;
    end else begin
      case (state)
        ST_IDLE: if (strobes.load) begin
          state   <= ST_RUN;
          stepCnt <= '0;
        end
        ST_RUN: if (strobes.finish) state <= ST_IDLE;
                else stepCnt <= stepCnt + 1'b1;
        default: state <= ST_IDLE;
      endcase
    end
  end
endmodule

// File: rtl/corr_datapath.sv
module corr_datapath
  import corr_pkg::*;
#(
  parameter int DWIDTH    = 4,
  parameter int NUM_TAP   = 16,
  parameter int MWIDTH    = 4,
  parameter int NUM_CHAN  = 2,
  parameter int NUM_SEQ   = 2,
  parameter int OS        = 1,
  parameter bit IS_SIGNED = 1'b0,
  localparam int STEPS = NUM_TAP / MWIDTH,
  localparam int DEPTH = OS * NUM_TAP,
  localparam int AW    = safeClog2(DEPTH),
  localparam int SW    = safeClog2(STEPS),
  localparam int CHW   = safeClog2(NUM_CHAN),
  localparam int SQW   = safeClog2(NUM_SEQ),
  localparam int CROWS = NUM_SEQ * STEPS,
  localparam int RAW   = safeClog2(CROWS),
  localparam int RW    = DWIDTH + $clog2(NUM_TAP) + 1
) (
  input  logic              clk,
  input  logic              rst,
  input  corrStrobes_t      strobes,
  input  logic [SW-1:0]     stepCnt,
  input  logic [DWIDTH-1:0] din,
  input  logic [CHW-1:0]    chanIn,
  input  logic [SQW-1:0]    codeSelIn,
  input  logic              blockStartIn,
  input  logic [RAW-1:0]    coeffAddr,
  input  logic [MWIDTH-1:0] coeffWdat,
  input  logic              coeffWr,
  output logic              ordy,
  output logic [RW-1:0]     dout,
  output logic [CHW-1:0]    chanOut,
  output logic              blockStartOut
);
  logic [DWIDTH-1:0] taps     [NUM_CHAN][DEPTH];
  logic [AW-1:0]     wrPtr    [NUM_CHAN];
  logic [MWIDTH-1:0] codeRows [CROWS];

  logic [CHW-1:0]  jobChan;
  logic [SQW-1:0]  jobSeq;
  logic [AW-1:0]   jobBase;
  logic            jobMark;
  logic signed [RW-1:0] acc, partial;
  logic [RAW-1:0]  rowIdx;
  logic [MWIDTH-1:0] codeRow;

  // row of the selected sequence that belongs to this accumulate step
  always_comb begin
    rowIdx  = RAW'(int'(jobSeq) * STEPS + int'(stepCnt));
    codeRow = codeRows[rowIdx];
  end

  // MWIDTH cells: tap k*MWIDTH+m reads the sample of age (k*MWIDTH+m)*OS
  always_comb begin
    int tapNo;
    int addr;
    logic [DWIDTH-1:0] smp;
    logic signed [RW-1:0] ext;
    partial = '0;
    for (int m = 0; m < MWIDTH; m++) begin
      tapNo = int'(stepCnt) * MWIDTH + m;
      addr  = int'(jobBase) - tapNo * OS;
      if (addr < 0) addr = addr + DEPTH;
      smp = taps[jobChan][addr[AW-1:0]];
      if (IS_SIGNED) ext = {{(RW-DWIDTH){smp[DWIDTH-1]}}, smp};
      else           ext = {{(RW-DWIDTH){1'b0}}, smp};
      if (codeRow[m])     partial = partial + ext;
      else if (IS_SIGNED) partial = partial - ext;
    end
  end

  always_ff @(posedge clk) begin
    ordy          <= 1'b0;
    blockStartOut <= 1'b0;
    if (rst) begin
      for (int c = 0; c < NUM_CHAN; c++) begin
        wrPtr[c] <= '0;
        for (int d = 0; d < DEPTH; d++) taps[c][d] <= '0;
      end
      for (int r = 0; r < CROWS; r++) codeRows[r] <= '0;
      jobChan <= '0;
      jobSeq  <= '0;
      jobBase <= '0;
      jobMark <= 1'b0;
      acc     <= '0;
      dout    <= '0;
      chanOut <= '0;
    end else begin
      if (coeffWr) codeRows[coeffAddr] <= coeffWdat;
      if (strobes.load) begin
        taps[chanIn][wrPtr[chanIn]] <= din;
        wrPtr[chanIn] <= (wrPtr[chanIn] == AW'(DEPTH - 1)) ? '0 : wrPtr[chanIn] + 1'b1;
        jobChan <= chanIn;
        jobSeq  <= codeSelIn;
        jobBase <= wrPtr[chanIn];
        jobMark <= blockStartIn;
        acc     <= '0;
      end
      if (strobes.step) acc <= acc + partial;
      if (strobes.finish) begin
        dout          <= acc + partial;
        ordy          <= 1'b1;
        chanOut       <= jobChan;
        blockStartOut <= jobMark;
      end
    end
  end
endmodule

// File: rtl/code_correlator.sv
module code_correlator
  import corr_pkg::*;
#(
  parameter int DWIDTH    = 4,
  parameter int NUM_TAP   = 16,
  parameter int MWIDTH    = 4,
  parameter int NUM_CHAN  = 2,
  parameter int NUM_SEQ   = 2,
  parameter int OS        = 1,
  parameter bit IS_SIGNED = 1'b0,
  localparam int STEPS = NUM_TAP / MWIDTH,
  localparam int SW    = safeClog2(STEPS),
  localparam int CHW   = safeClog2(NUM_CHAN),
  localparam int SQW   = safeClog2(NUM_SEQ),
  localparam int RAW   = safeClog2(NUM_SEQ * STEPS),
  localparam int RW    = DWIDTH + $clog2(NUM_TAP) + 1
) (
  input  logic              clk,
  input  logic              rst,
  output logic              crdy,
  input  logic              irdy,
  input  logic [DWIDTH-1:0] din,
  input  logic [CHW-1:0]    chanIn,
  input  logic [SQW-1:0]    codeSelIn,
  input  logic              blockStartIn,
  output logic              ordy,
  output logic [RW-1:0]     dout,
  output logic [CHW-1:0]    chanOut,
  output logic              blockStartOut,
  input  logic [RAW-1:0]    coeffAddr,
  input  logic [MWIDTH-1:0] coeffWdat,
  input  logic              coeffWr
);
  corrStrobes_t  strobes;
  logic [SW-1:0] stepCnt;

  corr_ctrl #(.STEPS(STEPS), .SW(SW)) u_ctrl (
    .clk(clk), .rst(rst), .irdy(irdy), .crdy(crdy),
    .strobes(strobes), .stepCnt(stepCnt)
  );

  corr_datapath #(
    .DWIDTH(DWIDTH), .NUM_TAP(NUM_TAP), .MWIDTH(MWIDTH), .NUM_CHAN(NUM_CHAN),
    .NUM_SEQ(NUM_SEQ), .OS(OS), .IS_SIGNED(IS_SIGNED)
  ) u_dp (
    .clk(clk), .rst(rst), .strobes(strobes), .stepCnt(stepCnt),
    .din(din), .chanIn(chanIn), .codeSelIn(codeSelIn), .blockStartIn(blockStartIn),
    .coeffAddr(coeffAddr), .coeffWdat(coeffWdat), .coeffWr(coeffWr),
    .ordy(ordy), .dout(dout), .chanOut(chanOut), .blockStartOut(blockStartOut)
  );
endmodule

// File: rtl/code_correlator_chk.sv
module code_correlator_chk #(
  parameter int NUM_TAP  = 16,
  parameter int MWIDTH   = 4,
  parameter int NUM_CHAN = 2,
  localparam int STEPS = NUM_TAP / MWIDTH,
  localparam int CHW   = (NUM_CHAN > 1) ? $clog2(NUM_CHAN) : 1
) (
  input logic           clk,
  input logic           rst,
  input logic           crdy,
  input logic           irdy,
  input logic           ordy,
  input logic           blockStartOut,
  input logic [CHW-1:0] chanOut
);
  logic        inFlight;
  logic [15:0] age;

  always_ff @(posedge clk) begin
    if (rst) begin
      inFlight <= 1'b0;
      age      <= '0;
    end else if (irdy && crdy) begin
      inFlight <= 1'b1;
      age      <= '0;
    end else begin
      if (ordy) inFlight <= 1'b0;
      if (inFlight && !ordy) age <= age + 1'b1;
    end
  end

  AST_BUSY_AFTER_ACCEPT: assert property (@(posedge clk) disable iff (rst)
    (irdy && crdy) |=> !crdy);  // R2
  AST_RESULT_PULSE: assert property (@(posedge clk) disable iff (rst)
    ordy |=> !ordy);  // R2
  AST_RESULT_LATENCY: assert property (@(posedge clk) disable iff (rst)
    ordy |-> (inFlight && int'(age) == STEPS));  // R2
  AST_READY_WITH_RESULT: assert property (@(posedge clk) disable iff (rst)
    ordy |-> crdy);  // R2
  AST_NO_JOB_WHILE_BUSY: assert property (@(posedge clk) disable iff (rst)
    !crdy |-> inFlight);  // R10
  AST_MARKER_ON_RESULT: assert property (@(posedge clk) disable iff (rst)
    blockStartOut |-> ordy);  // R8
  AST_CHAN_TAG_RANGE: assert property (@(posedge clk) disable iff (rst)
    ordy |-> (int'(chanOut) < NUM_CHAN));  // R7
endmodule

bind code_correlator code_correlator_chk #(
  .NUM_TAP(NUM_TAP), .MWIDTH(MWIDTH), .NUM_CHAN(NUM_CHAN)
) u_chk (
  .clk(clk), .rst(rst), .crdy(crdy), .irdy(irdy), .ordy(ordy),
  .blockStartOut(blockStartOut), .chanOut(chanOut)
);

// File: tb/code_correlator_tb.sv
module code_correlator_tb;
  localparam int CLK_PERIOD = 10;
  localparam int STEPS = 4;

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic irdy = 1'b0;
  logic [3:0] din = '0;
  logic chanIn = 1'b0;
  logic codeSelIn = 1'b0;
  logic blockStartIn = 1'b0;
  logic [2:0] coeffAddr = '0;
  logic [3:0] coeffWdat = '0;
  logic coeffWr = 1'b0;

  logic crdy0, crdy1, ordy0, ordy1, bso0, bso1, chOut0, chOut1;
  logic [8:0] dout0, dout1;

  always #(CLK_PERIOD/2) clk = ~clk;

  code_correlator u_dut (
    .clk(clk), .rst(rst), .crdy(crdy0), .irdy(irdy), .din(din), .chanIn(chanIn),
    .codeSelIn(codeSelIn), .blockStartIn(blockStartIn), .ordy(ordy0), .dout(dout0),
    .chanOut(chOut0), .blockStartOut(bso0), .coeffAddr(coeffAddr),
    .coeffWdat(coeffWdat), .coeffWr(coeffWr)
  );

  code_correlator #(.OS(2), .IS_SIGNED(1'b1)) u_dut_sgn (
    .clk(clk), .rst(rst), .crdy(crdy1), .irdy(irdy), .din(din), .chanIn(chanIn),
    .codeSelIn(codeSelIn), .blockStartIn(blockStartIn), .ordy(ordy1), .dout(dout1),
    .chanOut(chOut1), .blockStartOut(bso1), .coeffAddr(coeffAddr),
    .coeffWdat(coeffWdat), .coeffWr(coeffWr)
  );

  int checks = 0;
  int fails = 0;
  int cyc = 0;
  always @(posedge clk) cyc <= cyc + 1;

  // model state
  int hist [2][$];
  logic [15:0] code [2];
  int expVal [2][$];
  int expCh  [2][$];
  int expBs  [2][$];
  int expCyc [2][$];
  string expTag [2][$];

  task automatic check(input bit ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s: actual %0d expected %0d (cycle %0d)", req, act, exp, cyc);
    end
  endtask

  function automatic int model(input int ch, input int seq, input bit sgn, input int os);
    int sum = 0;
    for (int j = 0; j < 16; j++) begin
      int a = j * os;
      int v = (a < hist[ch].size()) ? hist[ch][a] : 0;
      if (sgn && v >= 8) v = v - 16;
      if (code[seq][j]) sum = sum + v;
      else if (sgn) sum = sum - v;
    end
    return sum;
  endfunction

  task automatic writeCode(input int seq, input logic [15:0] val);
    for (int k = 0; k < 4; k++) begin
      coeffAddr = 3'(seq * 4 + k);
      coeffWdat = val[4*k +: 4];
      coeffWr = 1'b1;
      @(negedge clk);
    end
    coeffWr = 1'b0;
    code[seq] = val;
  endtask

  task automatic drain();
    while (expVal[0].size() != 0 || expVal[1].size() != 0) @(negedge clk);
    @(negedge clk);
  endtask

  task automatic sendSample(input int ch, input int sel, input int d, input bit bs,
                            input string tag, input bit poke);
    int accCyc;
    while (!(crdy0 && crdy1)) @(negedge clk);
    chanIn = 1'(ch); codeSelIn = 1'(sel); din = 4'(d); blockStartIn = bs; irdy = 1'b1;
    hist[ch].push_front(d);
    @(posedge clk);
    #1;
    accCyc = cyc;
    for (int k = 0; k < 2; k++) begin
      expVal[k].push_back(model(ch, sel, k == 1, k == 1 ? 2 : 1));
      expCh[k].push_back(ch);
      expBs[k].push_back(int'(bs));
      expCyc[k].push_back(accCyc + STEPS);
      expTag[k].push_back(tag);
    end
    @(negedge clk);
    irdy = 1'b0; blockStartIn = 1'b0;
    check(crdy0 == 1'b0 && crdy1 == 1'b0, "R2 crdy low after accept", int'(crdy0), 0);
    if (poke) begin
      // R10: pulse while busy must be ignored
      chanIn = 1'(ch); din = 4'(15 - d); blockStartIn = 1'b1; irdy = 1'b1;
      @(negedge clk);
      irdy = 1'b0; blockStartIn = 1'b0;
    end
  endtask

  task automatic checkOut(input int k, input logic [8:0] d, input logic ch, input logic bs);
    int act;
    string pre;
    pre = (k == 0) ? "R3 R11" : "R4 R9";
    if (expVal[k].size() == 0) begin
      check(1'b0, "R10 unexpected result", 1, 0);
    end else begin
      int ev, ec, eb, ey;
      string tg;
      ev = expVal[k].pop_front(); ec = expCh[k].pop_front();
      eb = expBs[k].pop_front();  ey = expCyc[k].pop_front();
      tg = expTag[k].pop_front();
      act = (k == 1) ? int'(signed'(d)) : int'(d);
      check(act == ev, {pre, " ", tg, " value"}, act, ev);
      check(int'(ch) == ec, "R7 chanOut", int'(ch), ec);
      check(int'(bs) == eb, "R8 blockStartOut", int'(bs), eb);
      check(cyc == ey, "R2 result latency", cyc, ey);
    end
  endtask

  always @(negedge clk) begin
    if (!rst) begin
      if (ordy0) checkOut(0, dout0, chOut0, bso0);
      if (ordy1) checkOut(1, dout1, chOut1, bso1);
    end
  end

  initial begin
    repeat (50000) @(posedge clk);
    checks++; fails++;
    $display("FAIL R2 watchdog: actual hang expected completion");
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", checks, fails);
    $finish;
  end

  initial begin
    code[0] = '0; code[1] = '0;
    repeat (3) @(negedge clk);
    check(crdy0 && crdy1, "R1 crdy in reset", int'(crdy0), 1);
    rst = 1'b0;
    @(negedge clk);
    check(crdy0 && crdy1, "R1 crdy after reset", int'(crdy0 && crdy1), 1);
    check(!ordy0 && !ordy1, "R1 ordy after reset", int'(ordy0 || ordy1), 0);

    // R6: example sequence layout, low nibble in the first row
    writeCode(0, 16'ha6fc);
    writeCode(1, 16'hffff);
    // R1: empty history contributes zero
    sendSample(0, 1, 5, 1'b1, "R1", 1'b0);
    sendSample(1, 1, 9, 1'b0, "R1", 1'b0);
    drain();

    // R6 R7 R9: mixed channels, codes, markers, and busy pokes (R10)
    for (int i = 0; i < 60; i++) begin
      sendSample((i % 3 == 2) ? 1 : 0, (i / 4) % 2, (i * 7 + 3) % 16, (i % 5 == 0),
                 "R6", (i % 4 == 1));
    end
    drain();

    // R5: single-bit codes pick newest and oldest window samples
    writeCode(1, 16'h0001);
    sendSample(0, 1, 11, 1'b0, "R5", 1'b0);
    drain();
    writeCode(1, 16'h8000);
    sendSample(0, 1, 2, 1'b1, "R5", 1'b1);
    drain();

    // R6: rewrite sequence 0 with the second example code
    writeCode(0, 16'h0180);
    for (int i = 0; i < 6; i++) sendSample(i % 2, 0, 15 - i, 1'b0, "R6", 1'b0);
    drain();

    check(expVal[0].size() == 0 && expVal[1].size() == 0, "R10 no missing result",
          expVal[0].size() + expVal[1].size(), 0);
    repeat (10) @(negedge clk);
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", checks, fails);
    $finish;
  end
endmodule